// File: doc/BRIEF.md
# Load-Store Address and Byte-Lane Unit

This unit sits between the register read stage and the data memory port of a 32-bit processor. For each load or store request it adds the base register to the sign-extended 16-bit displacement, giving a 32-bit byte address. From that address and the access size it builds a 4-bit byte-enable mask and lines up the store data on the memory bus. A word access whose low two address bits are not zero raises a misalignment flag, and that access sends no byte enables and no memory request.

When the memory returns the 32-bit word for a load, the unit uses the lane, size and signedness it recorded when the load was issued. It takes out the addressed byte and fills the upper 24 bits with either the byte's top bit or zeros. A word load passes through unchanged. Lanes are numbered big-endian: address bits [1:0] = 0 select memory bits 31:24, and byte-enable bit 3 covers those bits.

Every result is registered. The memory request appears on the cycle after the request, and load data appears on the cycle after the memory response.

Top module: `lsu_top`

## Requirements
- R1: After reset every output is zero: mem_valid, mem_we, mem_addr, mem_be, mem_wdata, misalign, ld_valid and ld_data.
- R2: One cycle after req_valid, mem_addr equals req_base plus req_offset sign-extended to 32 bits, modulo 2^32 with no overflow indication. mem_valid is 1 in that cycle unless the access is misaligned.
- R3: An aligned word access (address bits [1:0] = 00) drives mem_be = 4'b1111. An aligned word store drives mem_wdata equal to req_wsrc.
- R4: A word access with address bits [1:0] not 00 sets misalign = 1, mem_be = 4'b0000 and mem_valid = 0. Such a load does not replace the lane, size and signedness recorded for the previous accepted load.
- R5: A byte access whose address bits [1:0] = k drives exactly one byte enable, bit 3-k, which covers memory data bits 31-8k down to 24-8k.
- R6: A byte store drives req_wsrc[7:0] on all four byte lanes of mem_wdata. The upper three bytes of req_wsrc have no effect.
- R7: A signed byte load returns on ld_data the byte in lane k of rsp_word, sign-extended from bit 7 to 32 bits.
- R8: An unsigned byte load returns the byte in lane k of rsp_word, zero-extended to 32 bits.
- R9: A word load returns rsp_word unchanged. ld_valid is 1 exactly one cycle after rsp_valid and 0 otherwise.
- R10: For every load, mem_we = 0 and mem_wdata = 0. For every store, mem_we = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_signed | input | 1 | Byte load sign-extends when 1 |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wsrc | input | 32 | Store source register value |
| rsp_valid | input | 1 | Memory returns load word this cycle |
| rsp_word | input | 32 | Word returned by memory |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte enables (bit 3 = bits 31:24) |
| mem_wdata | output | 32 | Lane-aligned store data |
| misalign | output | 1 | Misaligned word access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |

## Verification
The recorded lane and signedness are held from the load request until the memory response. If that state goes wrong, nothing shows until the response: the wrong byte or the wrong fill appears on ld_data one cycle after rsp_valid, while the request side still looks correct. An error in the adder or in the lane decoder shows on mem_addr and mem_be on the cycle after the request. The bench therefore sweeps every lane with every byte value for both signednesses, and it puts a misaligned load between an issue and its response so that the recorded state is exposed.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int ADDR_W = 32;
    localparam int OFS_W  = 16;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int LANE_AW = $clog2(LANES);

    typedef struct packed {
        logic                mem_valid;
        logic                mem_we;
        logic [ADDR_W-1:0]   mem_addr;
        logic [LANES-1:0]    mem_be;
        logic [DATA_W-1:0]   mem_wdata;
        logic                misalign;
        logic [LANE_AW-1:0]  pend_lane;
        logic                pend_byte;
        logic                pend_signed;
        logic                ld_valid;
        logic [DATA_W-1:0]   ld_data;
    } lsu_state_t;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int EXT_W = ADDR_W - OFS_W;
    logic [ADDR_W-1:0] ofs_ext;

    always_comb begin
        ofs_ext  = {{EXT_W{offset[OFS_W-1]}}, offset};
        eff_addr = base + ofs_ext;
    end
endmodule

// File: rtl/lsu_lane_ctl.sv
module lsu_lane_ctl #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W  = LANES * BYTE_W,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic               is_byte,
    input  logic               is_store,
    input  logic [LANE_AW-1:0] lane,
    input  logic [DATA_W-1:0]  src,
    output logic               misaligned,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata
);
    logic [LANES-1:0]  be_raw;
    logic [DATA_W-1:0] wd_raw;

    always_comb misaligned = !is_byte && (lane != '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int BIT = LANES - 1 - g;
        always_comb begin
            be_raw[BIT] = is_byte ? (lane == LANE_AW'(g)) : 1'b1;
            wd_raw[BIT*BYTE_W +: BYTE_W] =
                is_byte ? src[BYTE_W-1:0] : src[BIT*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        be    = misaligned ? '0 : be_raw;
        wdata = is_store ? wd_raw : '0;
    end
endmodule

// File: rtl/lsu_extract.sv
module lsu_extract #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W  = LANES * BYTE_W,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]  word,
    input  logic [LANE_AW-1:0] lane,
    input  logic               is_byte,
    input  logic               is_signed,
    output logic [DATA_W-1:0]  result
);
    logic [BYTE_W-1:0] lane_bytes [LANES];
    logic [BYTE_W-1:0] sel;
    logic              fill;

    for (genvar g = 0; g < LANES; g++) begin : g_pick
        always_comb lane_bytes[g] = word[(LANES-1-g)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        sel    = lane_bytes[lane];
        fill   = is_signed & sel[BYTE_W-1];
        result = is_byte ? {{(DATA_W-BYTE_W){fill}}, sel} : word;
    end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_byte,
    input  logic              req_signed,
    input  logic [31:0]       req_base,
    input  logic [15:0]       req_offset,
    input  logic [31:0]       req_wsrc,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_word,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              misalign,
    output logic              ld_valid,
    output logic [31:0]       ld_data
);
    lsu_state_t st_d, st_q;

    logic [ADDR_W-1:0]  eff_addr;
    logic               mis_w;
    logic [LANES-1:0]   be_w;
    logic [DATA_W-1:0]  wd_w;
    logic [DATA_W-1:0]  ext_w;

    lsu_agen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_agen (
        .base(req_base), .offset(req_offset), .eff_addr(eff_addr)
    );

    lsu_lane_ctl #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lane (
        .is_byte(req_byte), .is_store(req_store),
        .lane(eff_addr[LANE_AW-1:0]), .src(req_wsrc),
        .misaligned(mis_w), .be(be_w), .wdata(wd_w)
    );

    lsu_extract #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ext (
        .word(rsp_word), .lane(st_q.pend_lane), .is_byte(st_q.pend_byte),
        .is_signed(st_q.pend_signed), .result(ext_w)
    );

    always_comb begin
        st_d           = st_q;
        st_d.mem_valid = req_valid && !mis_w;
        st_d.misalign  = req_valid && mis_w;
        st_d.ld_valid  = rsp_valid;
        if (req_valid) begin
            st_d.mem_we    = req_store;
            st_d.mem_addr  = eff_addr;
            st_d.mem_be    = be_w;
            st_d.mem_wdata = wd_w;
            if (!req_store && !mis_w) begin
                st_d.pend_lane   = eff_addr[LANE_AW-1:0];
                st_d.pend_byte   = req_byte;
                st_d.pend_signed = req_signed;
            end
        end else begin
            st_d.mem_we = 1'b0;
            st_d.mem_be = '0;
        end
        if (rsp_valid) st_d.ld_data = ext_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mem_valid = st_q.mem_valid;
        mem_we    = st_q.mem_we;
        mem_addr  = st_q.mem_addr;
        mem_be    = st_q.mem_be;
        mem_wdata = st_q.mem_wdata;
        misalign  = st_q.misalign;
        ld_valid  = st_q.ld_valid;
        ld_data   = st_q.ld_data;
    end

    // R2: registered address equals base plus sign-extended offset
    a_r2_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mem_addr == ($past(req_base) +
            {{(ADDR_W-OFS_W){$past(req_offset[OFS_W-1])}}, $past(req_offset)}));

    // R3: aligned word access enables every lane
    a_r3_word_be: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_byte && ((req_base[1:0] + req_offset[1:0]) == 2'b00)
        |=> mem_be == 4'hF && mem_valid);

    // R4: misaligned word access raises the flag and sends nothing
    a_r4_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_byte && ((req_base[1:0] + req_offset[1:0]) != 2'b00)
        |=> misalign && !mem_valid && mem_be == 4'h0);

    // R5: byte access drives exactly one byte enable
    a_r5_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_byte |=> $countones(mem_be) == 1);

    // R9: load result valid follows the response by one cycle
    a_r9_ld_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid == $past(rsp_valid));

    // R10: loads never write
    a_r10_load_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store |=> !mem_we && mem_wdata == '0);
endmodule

// File: tb/tb_lsu_top.sv
module tb_lsu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_byte = 1'b0, req_signed = 1'b0;
    logic [31:0] req_base = '0, req_wsrc = '0, rsp_word = '0;
    logic [15:0] req_offset = '0;
    logic        rsp_valid = 1'b0;
    logic        mem_valid, mem_we, misalign, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    lsu_top dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] eaddr(input logic [31:0] b, input logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    // issue a request and check the memory side one cycle later
    task automatic access(input bit st, input bit by, input bit sg,
                          input logic [31:0] b, input logic [15:0] o, input logic [31:0] src);
        logic [31:0] a;
        int k;
        bit mis;
        a = eaddr(b, o);
        k = int'(a[1:0]);
        mis = !by && (k != 0);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_byte = by; req_signed = sg;
        req_base = b; req_offset = o; req_wsrc = src;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 addr", mem_addr, a);
        chk("R2/R4 valid", {31'b0, mem_valid}, {31'b0, !mis});
        chk("R4 misalign", {31'b0, misalign}, {31'b0, mis});
        chk("R10 we", {31'b0, mem_we}, {31'b0, st});
        if (mis)      chk("R4 be", {28'b0, mem_be}, 32'h0);
        else if (by)  chk("R5 be", {28'b0, mem_be}, 32'h8 >> k);
        else          chk("R3 be", {28'b0, mem_be}, 32'hF);
        if (!st)      chk("R10 wdata", mem_wdata, 32'h0);
        else if (by)  chk("R6 wdata", mem_wdata, {4{src[7:0]}});
        else          chk("R3 wdata", mem_wdata, src);
    endtask

    task automatic respond(input logic [31:0] w, input logic [31:0] exp, input string req);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_word = w;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R9 ld_valid", {31'b0, ld_valid}, 32'h1);
        chk(req, ld_data, exp);
        @(negedge clk);
        chk("R9 ld_valid low", {31'b0, ld_valid}, 32'h0);
    endtask

    function automatic logic [31:0] expect_byte(input logic [31:0] w, input int k, input bit sg);
        logic [7:0] v;
        v = 8'((w >> (8 * (3 - k))) & 32'hFF);
        return sg ? {{24{v[7]}}, v} : {24'b0, v};
    endfunction

    initial begin
        logic [31:0] bases [4];
        logic [15:0] offs  [4];
        bases = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h0000_0010, 32'h1234_5678};
        offs  = '{16'h0004, 16'h0020, 16'h8000, 16'hFFF8};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mem_valid", {31'b0, mem_valid}, 0);
        chk("R1 mem_addr", mem_addr, 0);
        chk("R1 mem_be", {28'b0, mem_be}, 0);
        chk("R1 mem_wdata", mem_wdata, 0);
        chk("R1 misalign", {31'b0, misalign}, 0);
        chk("R1 ld", {30'b0, ld_valid, mem_we}, 0);
        chk("R1 ld_data", ld_data, 0);
        rst_n = 1'b1;
        // R2..R6, R10: request side sweep incl. wraparound (R2)
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++)
                for (int m = 0; m < 4; m++)
                    access(m[0], m[1], 1'b0, bases[p] + 32'(k), offs[p],
                           32'hA1B2_C300 | 32'(p * 16 + k));
        // R7 R8: every lane, every byte value, both fills
        for (int k = 0; k < 4; k++)
            for (int v = 0; v < 256; v++)
                for (int s = 0; s < 2; s++) begin
                    logic [31:0] w;
                    w = 32'h5A5A_5A5A;
                    w[8*(3-k) +: 8] = 8'(v);
                    access(1'b0, 1'b1, s[0], 32'h0000_2000 + 32'(k), 16'h0000, 32'h0);
                    respond(w, expect_byte(w, k, s[0]), s[0] ? "R7 signed byte" : "R8 unsigned byte");
                end
        // R9: word loads pass through
        access(1'b0, 1'b0, 1'b1, 32'h0000_3000, 16'h0010, 32'h0);
        respond(32'h8765_4321, 32'h8765_4321, "R9 word load");
        access(1'b0, 1'b0, 1'b0, 32'h0000_3000, 16'hFFFC, 32'h0);
        respond(32'hFEDC_BA98, 32'hFEDC_BA98, "R9 word load");
        // R4: misaligned load between issue and response leaves recorded lane intact
        access(1'b0, 1'b1, 1'b1, 32'h0000_4002, 16'h0000, 32'h0);
        access(1'b0, 1'b0, 1'b0, 32'h0000_4001, 16'h0000, 32'h0);
        respond(32'h1122_8344, 32'hFFFF_FF83, "R4 pending kept");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule